// File: doc/BRIEF.md
# Affine-Gap Local Alignment Cell

This block is one processing element of a linear systolic chain that scores local sequence alignment with separate gap-open and gap-extend costs. Each cell stands for one symbol of the query. It holds that symbol's column of substitution scores in a small lookup table. Subject symbols stream through the chain as table addresses, one per valid step. Each cell takes the subject symbol, the left neighbour's H score and the left neighbour's E score. It keeps its own previous H and F and the left H of the previous step, which serves as the diagonal term. From these it forms new H, E and F scores. It forwards the symbol, its new H, its new E and a running maximum of every H seen so far along the chain.

Before a scan, the table column and the two penalties are loaded through a configuration write path. During the scan a first-symbol flag travels with the opening symbol of each subject sequence. That flag restarts the cell's recurrence state from zero. A new sequence can therefore follow the previous one on the very next step, with no gap. A valid strobe travels with the data. When it is low, the cell keeps all of its state. The last cell of a chain presents the best local alignment score of a whole sequence on the step that carries that sequence's final symbol.

Top module: `sw_affine_cell`

## Requirements
- R1: The new H is the largest of 0, the new E, the new F and the diagonal sum, so out_h is never negative.
- R2: The new E is the larger of (in_h minus the open penalty) and (in_e minus the extend penalty), and it leaves the cell on out_e.
- R3: The new F is the larger of (the cell's previous H minus the open penalty) and (the cell's previous F minus the extend penalty).
- R4: The diagonal sum is the in_h of the previous valid step plus the signed table entry addressed by in_sym.
- R5: A step with in_first high takes the previous H, previous F, diagonal H and running maximum as zero before it computes.
- R6: Every addition and subtraction saturates at the signed score bounds (+32767 and -32768 at the default 16-bit width).
- R7: out_max is the largest of the previous running maximum, the new H and in_max.
- R8: The results for a step appear two clock cycles after the step is presented, with out_valid high, and in_sym and in_first are forwarded unchanged in the same cycle.
- R9: While in_valid is low, no state changes; out_valid drops and out_h, out_e and out_max hold their values.
- R10: A step with in_first high may directly follow the last step of the previous sequence, and its scores do not depend on that sequence.
- R11: A configuration write with cfg_lut_we high stores cfg_lut_data (signed, SUB_W bits) at entry cfg_lut_addr. A write with cfg_pen_we high loads cfg_open and cfg_extend as the open and extend penalties.
- R12: Reset clears all outputs, every table entry and both penalties to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lut_we | input | 1 | Write strobe for one substitution table entry |
| cfg_lut_addr | input | ADDR_W (5) | Table entry to write |
| cfg_lut_data | input | SUB_W (8) | Signed substitution score to store |
| cfg_pen_we | input | 1 | Write strobe for both gap penalties |
| cfg_open | input | SCORE_W (16) | Gap-open penalty |
| cfg_extend | input | SCORE_W (16) | Gap-extend penalty |
| in_valid | input | 1 | Step strobe from the left neighbour |
| in_first | input | 1 | Marks the first symbol of a subject sequence |
| in_sym | input | ADDR_W (5) | Subject symbol as a table address |
| in_h | input | SCORE_W (16) | Left neighbour's H, signed |
| in_e | input | SCORE_W (16) | Left neighbour's E, signed |
| in_max | input | SCORE_W (16) | Running maximum from the left, signed |
| out_valid | output | 1 | Step strobe to the right neighbour |
| out_first | output | 1 | Forwarded first-symbol flag |
| out_sym | output | ADDR_W (5) | Forwarded subject symbol |
| out_h | output | SCORE_W (16) | New H of this cell, signed |
| out_e | output | SCORE_W (16) | New E of this cell, signed |
| out_max | output | SCORE_W (16) | Updated running maximum, signed |

## Verification
The first pattern uses equal open and extend costs with mixed matching and mismatching symbols and varied left scores. It separates the diagonal term from the two gap terms when they carry the same cost. A second run with a large open cost and a small extend cost feeds runs of matches and then mismatches. There the F score must follow the extend cost instead of reopening, and a step with a high in_e must take the extend path of E. Back-to-back sequences, steps with no valid strobe in between, and left maxima above the cell's own H show whether state is cleared, held or merged at the correct step. Left scores and table entries near the signed limits show that the diagonal sum and both gap terms saturate instead of wrapping.

// File: rtl/sw_cell_pkg.sv
package sw_cell_pkg;

    localparam int SCORE_W   = 16;
    localparam int SUB_W     = 8;
    localparam int ADDR_W    = 5;
    localparam int LUT_DEPTH = 1 << ADDR_W;

    typedef logic signed [SCORE_W-1:0] score_t;
    typedef logic signed [SUB_W-1:0]   sub_t;
    typedef logic [ADDR_W-1:0]         sym_t;

    // Result of the lookup stage, consumed by the scoring stage.
    typedef struct packed {
        logic   first;
        sym_t   sym;
        score_t gap_row;   // new E of this step
        score_t diag_sum;  // diagonal H plus substitution score
        score_t max_in;    // running maximum from the left
    } front_t;

    // Registered result handed to the right neighbour.
    typedef struct packed {
        logic   first;
        sym_t   sym;
        score_t h;
        score_t e;
        score_t best;
    } cell_out_t;

    // Clamp a one-bit-wider signed value to the score range.
    function automatic score_t clamp_wide(input logic signed [SCORE_W:0] s);
        if (s[SCORE_W] != s[SCORE_W-1])
            return s[SCORE_W] ? {1'b1, {(SCORE_W-1){1'b0}}}
                              : {1'b0, {(SCORE_W-1){1'b1}}};
        return s[SCORE_W-1:0];
    endfunction

    function automatic score_t sat_add(input score_t a, input score_t b);
        logic signed [SCORE_W:0] s;
        s = $signed({a[SCORE_W-1], a}) + $signed({b[SCORE_W-1], b});
        return clamp_wide(s);
    endfunction

    function automatic score_t sat_sub(input score_t a, input score_t b);
        logic signed [SCORE_W:0] s;
        s = $signed({a[SCORE_W-1], a}) - $signed({b[SCORE_W-1], b});
        return clamp_wide(s);
    endfunction

    function automatic score_t widen_sub(input sub_t v);
        return {{(SCORE_W-SUB_W){v[SUB_W-1]}}, v};
    endfunction

    function automatic score_t smax(input score_t a, input score_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sw_sub_lut.sv
module sw_sub_lut
    import sw_cell_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  sym_t   wr_addr,
    input  sub_t   wr_data,
    input  sym_t   rd_addr,
    output score_t rd_score
);

    sub_t entries [LUT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LUT_DEPTH; k++) entries[k] <= '0;
        end else if (wr_en) begin
            entries[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read so that lookup and diagonal add share one cycle.
    assign rd_score = widen_sub(entries[rd_addr]);

endmodule

// File: rtl/sw_front_stage.sv
module sw_front_stage
    import sw_cell_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   in_first,
    input  sym_t   in_sym,
    input  score_t in_h,
    input  score_t in_e,
    input  score_t in_max,
    input  score_t sub_score,
    input  score_t pen_open,
    input  score_t pen_ext,
    output logic   front_valid,
    output front_t front_q
);

    score_t diag_q;      // left H of the previous valid step
    score_t diag_base;
    front_t front_d;

    always_comb begin
        diag_base        = in_first ? '0 : diag_q;
        front_d.first    = in_first;
        front_d.sym      = in_sym;
        front_d.gap_row  = smax(sat_sub(in_h, pen_open), sat_sub(in_e, pen_ext));
        front_d.diag_sum = sat_add(diag_base, sub_score);
        front_d.max_in   = in_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            front_valid <= 1'b0;
            front_q     <= '0;
            diag_q      <= '0;
        end else begin
            front_valid <= in_valid;
            if (in_valid) begin
                front_q <= front_d;
                diag_q  <= in_h;
            end
        end
    end

endmodule

// File: rtl/sw_score_stage.sv
module sw_score_stage
    import sw_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      front_valid,
    input  front_t    front_q,
    input  score_t    pen_open,
    input  score_t    pen_ext,
    output logic      cell_valid,
    output cell_out_t cell_q
);

    score_t h_q;         // own H of the previous step (upper H)
    score_t f_q;         // own F of the previous step (upper F)
    score_t best_q;      // own running maximum
    score_t up_h, up_f, prev_best;
    score_t f_new, h_new, best_new;

    always_comb begin
        up_h      = front_q.first ? '0 : h_q;
        up_f      = front_q.first ? '0 : f_q;
        prev_best = front_q.first ? '0 : best_q;
        f_new     = smax(sat_sub(up_h, pen_open), sat_sub(up_f, pen_ext));
        h_new     = smax(smax('0, front_q.gap_row), smax(f_new, front_q.diag_sum));
        best_new  = smax(smax(prev_best, h_new), front_q.max_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_valid <= 1'b0;
            cell_q     <= '0;
            h_q        <= '0;
            f_q        <= '0;
            best_q     <= '0;
        end else begin
            cell_valid <= front_valid;
            if (front_valid) begin
                h_q          <= h_new;
                f_q          <= f_new;
                best_q       <= best_new;
                cell_q.first <= front_q.first;
                cell_q.sym   <= front_q.sym;
                cell_q.h     <= h_new;
                cell_q.e     <= front_q.gap_row;
                cell_q.best  <= best_new;
            end
        end
    end

endmodule

// File: rtl/sw_affine_cell.sv
module sw_affine_cell
    import sw_cell_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_lut_we,
    input  logic [ADDR_W-1:0]  cfg_lut_addr,
    input  logic [SUB_W-1:0]   cfg_lut_data,
    input  logic               cfg_pen_we,
    input  logic [SCORE_W-1:0] cfg_open,
    input  logic [SCORE_W-1:0] cfg_extend,
    input  logic               in_valid,
    input  logic               in_first,
    input  logic [ADDR_W-1:0]  in_sym,
    input  logic [SCORE_W-1:0] in_h,
    input  logic [SCORE_W-1:0] in_e,
    input  logic [SCORE_W-1:0] in_max,
    output logic               out_valid,
    output logic               out_first,
    output logic [ADDR_W-1:0]  out_sym,
    output logic [SCORE_W-1:0] out_h,
    output logic [SCORE_W-1:0] out_e,
    output logic [SCORE_W-1:0] out_max
);

    score_t    pen_open_q;
    score_t    pen_ext_q;
    score_t    sub_score;
    logic      front_valid;
    front_t    front_q;
    logic      cell_valid;
    cell_out_t cell_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pen_open_q <= '0;
            pen_ext_q  <= '0;
        end else if (cfg_pen_we) begin
            pen_open_q <= cfg_open;
            pen_ext_q  <= cfg_extend;
        end
    end

    sw_sub_lut u_lut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_lut_we),
        .wr_addr  (cfg_lut_addr),
        .wr_data  (cfg_lut_data),
        .rd_addr  (in_sym),
        .rd_score (sub_score)
    );

    sw_front_stage u_front (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_first    (in_first),
        .in_sym      (in_sym),
        .in_h        (in_h),
        .in_e        (in_e),
        .in_max      (in_max),
        .sub_score   (sub_score),
        .pen_open    (pen_open_q),
        .pen_ext     (pen_ext_q),
        .front_valid (front_valid),
        .front_q     (front_q)
    );

    sw_score_stage u_score (
        .clk         (clk),
        .rst         (rst),
        .front_valid (front_valid),
        .front_q     (front_q),
        .pen_open    (pen_open_q),
        .pen_ext     (pen_ext_q),
        .cell_valid  (cell_valid),
        .cell_q      (cell_q)
    );

    assign out_valid = cell_valid;
    assign out_first = cell_q.first;
    assign out_sym   = cell_q.sym;
    assign out_h     = cell_q.h;
    assign out_e     = cell_q.e;
    assign out_max   = cell_q.best;

endmodule

// File: rtl/sw_affine_cell_chk.sv
module sw_affine_cell_chk
    import sw_cell_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_first,
    input logic [ADDR_W-1:0]  in_sym,
    input logic               out_valid,
    input logic               out_first,
    input logic [ADDR_W-1:0]  out_sym,
    input logic [SCORE_W-1:0] out_h,
    input logic [SCORE_W-1:0] out_e,
    input logic [SCORE_W-1:0] out_max
);

    // Edges seen since reset was released, saturating at 3.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R1: a valid H score is never negative.
    assert_h_nonneg_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_h[SCORE_W-1]);

    // R7: the running maximum covers the score it was merged with.
    assert_max_cover_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_max) >= $signed(out_h)));

    // R8: a step presented two cycles ago produces a result now.
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 2)));

    // R8: symbol and first flag travel with the result.
    assert_forward_R8: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |->
            (out_sym == $past(in_sym, 2) && out_first == $past(in_first, 2)));

    // R9: without a valid step the forwarded scores hold.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && !out_valid) |->
            ($stable(out_h) && $stable(out_e) && $stable(out_max)));

endmodule

bind sw_affine_cell sw_affine_cell_chk u_chk (.*);

// File: tb/tb_sw_affine_cell.sv
module tb_sw_affine_cell;
    import sw_cell_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_lut_we = 1'b0;
    logic [ADDR_W-1:0]  cfg_lut_addr = '0;
    logic [SUB_W-1:0]   cfg_lut_data = '0;
    logic               cfg_pen_we = 1'b0;
    logic [SCORE_W-1:0] cfg_open = '0;
    logic [SCORE_W-1:0] cfg_extend = '0;
    logic               in_valid = 1'b0;
    logic               in_first = 1'b0;
    logic [ADDR_W-1:0]  in_sym = '0;
    logic [SCORE_W-1:0] in_h = '0;
    logic [SCORE_W-1:0] in_e = '0;
    logic [SCORE_W-1:0] in_max = '0;
    logic               out_valid;
    logic               out_first;
    logic [ADDR_W-1:0]  out_sym;
    logic [SCORE_W-1:0] out_h;
    logic [SCORE_W-1:0] out_e;
    logic [SCORE_W-1:0] out_max;

    always #5 clk = ~clk;

    sw_affine_cell dut (.*);

    typedef struct {
        int    sym;
        bit    first;
        int    h;
        int    e;
        int    mx;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;

    // Bench-side model state, built only from the requirements.
    int lut_m [LUT_DEPTH];
    int open_m = 0, ext_m = 0;
    int mh = 0, mf = 0, md = 0, mm = 0;

    function automatic int sat(input int v);
        int hi, lo;
        hi = (1 << (SCORE_W - 1)) - 1;
        lo = -(1 << (SCORE_W - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic send(input int sym, input bit first, input int inh,
                        input int ine, input int inmax, input string tag);
        exp_t x;
        int   e, ds, f, h;
        e = imax(sat(inh - open_m), sat(ine - ext_m));
        if (first) begin
            mh = 0; mf = 0; md = 0; mm = 0;
        end
        ds = sat(md + lut_m[sym]);
        md = inh;
        f  = imax(sat(mh - open_m), sat(mf - ext_m));
        h  = imax(imax(0, e), imax(f, ds));
        mh = h;
        mf = f;
        mm = imax(imax(mm, h), inmax);
        x.sym = sym; x.first = first; x.h = h; x.e = e; x.mx = mm; x.tag = tag;
        q.push_back(x);
        in_valid = 1'b1;
        in_first = first;
        in_sym   = ADDR_W'(sym);
        in_h     = SCORE_W'(inh);
        in_e     = SCORE_W'(ine);
        in_max   = SCORE_W'(inmax);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_first = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        idle(1);
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr_lut(input int a, input int v);
        cfg_lut_we   = 1'b1;
        cfg_lut_addr = ADDR_W'(a);
        cfg_lut_data = SUB_W'(v);
        @(negedge clk);
        cfg_lut_we   = 1'b0;
        lut_m[a]     = v;
    endtask

    task automatic wr_pen(input int o, input int x);
        cfg_pen_we = 1'b1;
        cfg_open   = SCORE_W'(o);
        cfg_extend = SCORE_W'(x);
        @(negedge clk);
        cfg_pen_we = 1'b0;
        open_m     = o;
        ext_m      = x;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: pop and compare each result as it leaves the cell.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "result without a pending step", 1, 0);
                end else begin
                    exp_t x;
                    bit   ok;
                    x  = q.pop_front();
                    ok = ($signed(out_h) == x.h) && ($signed(out_e) == x.e) &&
                         ($signed(out_max) == x.mx) && (int'(out_sym) == x.sym) &&
                         (out_first == x.first);
                    checks++;
                    if (!ok) begin
                        errors++;
                        $display("FAIL %s actual h=%0d e=%0d max=%0d sym=%0d first=%0d expected h=%0d e=%0d max=%0d sym=%0d first=%0d",
                                 x.tag, $signed(out_h), $signed(out_e), $signed(out_max),
                                 out_sym, out_first, x.h, x.e, x.mx, x.sym, x.first);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < LUT_DEPTH; k++) lut_m[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state of outputs.
        check(out_valid == 1'b0, "R12", "out_valid after reset", int'(out_valid), 0);
        check(out_h == '0, "R12", "out_h after reset", int'(out_h), 0);
        check(out_max == '0, "R12", "out_max after reset", int'(out_max), 0);

        // R12: zero table and zero penalties after reset.
        send(4, 1'b1, 5, 3, 0, "R12");
        drain();

        // R11: load the query column (symbol 3 matches) and penalties.
        for (int a = 0; a < LUT_DEPTH; a++) wr_lut(a, (a == 3) ? 2 : -1);
        wr_lut(7, 100);
        wr_lut(8, -128);
        wr_lut(9, 50);
        wr_pen(1, 1);
        send(9, 1'b1, 0, 0, 0, "R11");
        drain();

        // R8: result appears exactly two cycles after the step.
        send(3, 1'b1, 0, 0, 0, "R8");
        idle(0);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R8", "out_valid one cycle after step", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R8", "out_valid two cycles after step", int'(out_valid), 1);
        drain();

        // R4: diagonal uses the previous left H plus the table entry.
        send(0, 1'b1, 10, 0, 0, "R4");
        send(3, 1'b0, 0, 0, 0, "R4");
        drain();

        // R1: equal open/extend costs, mixed symbols and left scores.
        for (int k = 0; k < 12; k++)
            send((k % 3 == 0) ? 3 : (k * 7) % LUT_DEPTH, k == 0,
                 (k * 5) % 9, (k * 3) % 7 - 3, k % 4, "R1");
        drain();

        // R3: large open, small extend; matches then mismatches.
        wr_pen(4, 1);
        send(3, 1'b1, 0, 0, 0, "R3");
        send(3, 1'b0, 0, 0, 0, "R3");
        send(3, 1'b0, 0, 0, 0, "R3");
        send(0, 1'b0, 0, 0, 0, "R3");
        send(0, 1'b0, 0, 0, 0, "R3");
        send(0, 1'b0, 0, 0, 0, "R3");
        send(3, 1'b0, 0, 0, 0, "R3");

        // R2: E takes the extend path when in_e is high.
        send(0, 1'b0, 20, 18, 0, "R2");
        send(0, 1'b0, 30, 1, 0, "R2");

        // R10 and R5: a new sequence directly after the last step.
        send(3, 1'b1, 2, 0, 0, "R10");
        send(3, 1'b0, 9, 0, 0, "R10");
        send(3, 1'b1, 0, 0, 0, "R5");
        send(0, 1'b0, 0, 0, 0, "R5");
        drain();

        // R7: in_max above the cell's own H, then kept afterwards.
        wr_pen(1, 1);
        send(3, 1'b1, 0, 0, 500, "R7");
        send(0, 1'b0, 0, 0, 0, "R7");
        send(3, 1'b1, 0, 0, 0, "R7");

        // R9: bubbles hold state; results resume consistently.
        send(3, 1'b0, 4, 0, 0, "R9");
        send(3, 1'b0, 1, 0, 0, "R9");
        idle(4);
        check(out_valid == 1'b0, "R9", "out_valid during bubbles", int'(out_valid), 0);
        check($signed(out_h) == mh, "R9", "out_h held during bubbles", $signed(out_h), mh);
        check($signed(out_max) == mm, "R9", "out_max held during bubbles", $signed(out_max), mm);
        send(3, 1'b0, 0, 0, 0, "R9");
        idle(2);
        send(0, 1'b0, 3, 0, 0, "R9");
        drain();

        // R6: saturation at both ends of the score range.
        send(0, 1'b1, 32767, -32768, 0, "R6");
        send(7, 1'b0, 100, -32768, 0, "R6");
        send(8, 1'b0, -32768, -32768, 0, "R6");
        send(8, 1'b0, 0, -32768, 0, "R6");
        drain();

        check(q.size() == 0, "R8", "pending results at end", q.size(), 0);
        summary();
        $finish;
    end

endmodule